// File: doc/BRIEF.md
# Interrupt File Priority Core

This block keeps the interrupt state of one or more interrupt files. A file is also called a page. Each file has a pending bit and an enable bit for every interrupt identity, a delivery switch and a threshold. The block searches each file without pause for the smallest identity that is both pending and enabled. That identity is the winner. For every file it drives one level interrupt line, and the line is high only while delivery is on and a winner exists. Identity 0 never takes part in the search.

Three kinds of request change the state:

- **Set-pending:** an incoming message marks one identity of one file as pending.
- **Claim:** a write to a file's top-interrupt register removes the pending mark of that file's current winner.
- **Register access:** any of a file's registers can be read, and any of them can be rewritten with a bit mask.

Bus decoding and privilege routing belong to the neighbouring blocks. A machine-level instance is built with one file. A supervisor instance has file 0 plus one file for each guest.

The number of identities per file is `MAX_ID + 1`. `MAX_ID` has the form 2^k−1 and lies between 63 and 2047.

Top module: `ifp_core`

## Requirements
- R1: After reset, every pending bit, enable bit, delivery bit and threshold is 0. Every interrupt line is low, and every register reads back as 0.
- R2: A set-pending request with a nonzero identity sets that identity's pending bit in the addressed file. A request with identity 0 changes nothing.
- R3: Access selector 3 addresses a pending word and selector 4 an enable word. Word w bit b holds identity 32·w+b. Only the bits selected in the write mask take the write data. Bit 0 of word 0 always reads 0.
- R4: A read of the top register (selector 2) returns the winner in bits 16 and up and again in the low bits. The winner is the smallest nonzero identity that is pending, enabled and eligible. The read returns 0 when there is no winner.
- R5: The threshold register has selector 1. A nonzero threshold makes only the identities strictly below it eligible, and a threshold of 0 masks nothing. A write changes only the low log2(MAX_ID+1) bits, within the write mask.
- R6: A file's interrupt line is a register. It is high exactly when that file's delivery bit is 1 and a winner exists. It follows each state change on the same clock edge that stores the change.
- R7: A write to the top register clears only the pending bit of the current winner and ignores the write data. When there is no winner, the write has no effect.
- R8: When a claim and a set-pending request reach the same file in the same cycle, the set-pending request is applied last. An identity that is both claimed and set stays pending.
- R9: Files are independent. A request addressed to one file leaves every other file's state and interrupt line unchanged.
- R10: The delivery register has selector 0. Only bit 0 is stored, and it reads back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_valid | input | 1 | Set-pending request strobe |
| set_page | input | PW | File addressed by the set-pending request |
| set_id | input | IW | Identity to mark pending |
| acc_valid | input | 1 | Register access strobe |
| acc_we | input | 1 | Access is a write (masked) |
| acc_op | input | 3 | Selector: 0 delivery, 1 threshold, 2 top, 3 pending word, 4 enable word |
| acc_page | input | PW | File addressed by the access |
| acc_idx | input | WW | Word index for pending and enable words |
| acc_wdata | input | 32 | Write data |
| acc_wmask | input | 32 | Write bit mask |
| acc_rdata | output | 32 | Read data from the current state; combinational within the access cycle |
| irq | output | NUM_PAGES | Per-file level interrupt line |

## Verification
The winner search is tried with several patterns of pending and enabled identities:

- A single identity pending.
- Several identities pending in both words. This shows whether the lowest one wins and not the newest.
- An identity pending but not enabled. This shows that the pending and enable bits are combined.

Threshold values of 0, exactly at the winner, just above it, and with high bits set are used. They show the boundary between strict and inclusive comparison, and whether the threshold field is masked. Claims are issued back to back, with no winner present, and together with a set-pending request for the same identity or for a different one. These cases separate the clearing of one bit from the clearing of many, and they show the order in which a claim and a set-pending request in the same cycle are applied. A second file is then driven to show that nothing leaks between files.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

    localparam int DATA_W     = 32;
    localparam int TOP_ID_LSB = 16;

    typedef enum logic [2:0] {
        OP_DELIV  = 3'd0,
        OP_THRESH = 3'd1,
        OP_TOP    = 3'd2,
        OP_PEND   = 3'd3,
        OP_ENAB   = 3'd4
    } ifp_op_e;

endpackage

// File: rtl/ifp_ffs.sv
// Lowest-set-bit search above index 0, limited by a threshold (0 = no limit).
module ifp_ffs #(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] thr,
    output logic          found,
    output logic [IW-1:0] id
);

    always_comb begin
        found = 1'b0;
        id    = '0;
        for (int i = N - 1; i >= 1; i--) begin
            if (vec[i] && ((thr == '0) || (IW'(i) < thr))) begin
                found = 1'b1;
                id    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ifp_page.sv
module ifp_page
    import ifp_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int IW      = 6,
    parameter int WW      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_hit,
    input  logic [IW-1:0]     set_id,
    input  logic              acc_hit,
    input  logic              acc_we,
    input  ifp_op_e           acc_op,
    input  logic [WW-1:0]     acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] acc_wmask,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_IDS-1:0] pend;
        logic [NUM_IDS-1:0] en;
        logic               deliv;
        logic [IW-1:0]      thr;
    } state_t;

    state_t        st_d, st_q;
    logic          irq_d, irq_q;
    logic          found_q, found_d;
    logic [IW-1:0] top_q, top_d;
    logic          claim;

    // Winner of the stored state: feeds reads and claims.
    ifp_ffs #(.N(NUM_IDS), .IW(IW)) u_ffs_q (
        .vec   (st_q.pend & st_q.en),
        .thr   (st_q.thr),
        .found (found_q),
        .id    (top_q)
    );

    // Winner of the next state: feeds the registered interrupt line.
    ifp_ffs #(.N(NUM_IDS), .IW(IW)) u_ffs_d (
        .vec   (st_d.pend & st_d.en),
        .thr   (st_d.thr),
        .found (found_d),
        .id    (top_d)
    );

    assign claim = acc_hit && acc_we && (acc_op == OP_TOP);

    always_comb begin
        st_d = st_q;
        if (acc_hit && acc_we) begin
            case (acc_op)
                OP_DELIV: begin
                    if (acc_wmask[0]) st_d.deliv = acc_wdata[0];
                end
                OP_THRESH: begin
                    st_d.thr = (st_q.thr & ~acc_wmask[IW-1:0])
                             | (acc_wdata[IW-1:0] & acc_wmask[IW-1:0]);
                end
                OP_TOP: begin
                    if (found_q) st_d.pend[top_q] = 1'b0;
                end
                OP_PEND: begin
                    for (int b = 0; b < DATA_W; b++) begin
                        if (acc_wmask[b]) st_d.pend[{acc_idx, 5'(b)}] = acc_wdata[b];
                    end
                end
                OP_ENAB: begin
                    for (int b = 0; b < DATA_W; b++) begin
                        if (acc_wmask[b]) st_d.en[{acc_idx, 5'(b)}] = acc_wdata[b];
                    end
                end
                default: ;
            endcase
        end
        // Set-pending is applied after any claim in the same cycle.
        if (set_hit && (set_id != '0)) st_d.pend[set_id] = 1'b1;
        st_d.pend[0] = 1'b0;
        st_d.en[0]   = 1'b0;
    end

    assign irq_d = st_d.deliv && found_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            irq_q <= irq_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (acc_op)
            OP_DELIV:  rdata[0] = st_q.deliv;
            OP_THRESH: rdata[IW-1:0] = st_q.thr;
            OP_TOP: begin
                rdata[TOP_ID_LSB +: IW] = top_q;
                rdata[IW-1:0]           = top_q;
            end
            OP_PEND:   rdata = st_q.pend[{acc_idx, 5'd0} +: DATA_W];
            OP_ENAB:   rdata = st_q.en[{acc_idx, 5'd0} +: DATA_W];
            default:   rdata = '0;
        endcase
    end

    assign irq = irq_q;

    // R2
    set_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit && set_id != '0) |=> st_q.pend[$past(set_id)]);

    // R7
    claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && found_q && !(set_hit && set_id == top_q)) |=> !st_q.pend[$past(top_q)]);

    // R3
    id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend[0] && !st_q.en[0]);

    // R5
    below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found_q && st_q.thr != '0) |-> (top_q < st_q.thr));

    // R4
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found_q |-> ((st_q.pend & st_q.en & ((NUM_IDS'(1) << top_q) - NUM_IDS'(1))) == '0));

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (st_q.deliv && found_q));

endmodule

// File: rtl/ifp_core.sv
module ifp_core
    import ifp_pkg::*;
#(
    parameter  int NUM_PAGES = 2,
    parameter  int MAX_ID    = 63,
    localparam int NUM_IDS   = MAX_ID + 1,
    localparam int IW        = $clog2(NUM_IDS),
    localparam int NW        = NUM_IDS / DATA_W,
    localparam int WW        = (NW > 1) ? $clog2(NW) : 1,
    localparam int PW        = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid,
    input  logic [PW-1:0]        set_page,
    input  logic [IW-1:0]        set_id,
    input  logic                 acc_valid,
    input  logic                 acc_we,
    input  logic [2:0]           acc_op,
    input  logic [PW-1:0]        acc_page,
    input  logic [WW-1:0]        acc_idx,
    input  logic [DATA_W-1:0]    acc_wdata,
    input  logic [DATA_W-1:0]    acc_wmask,
    output logic [DATA_W-1:0]    acc_rdata,
    output logic [NUM_PAGES-1:0] irq
);

    logic [DATA_W-1:0] pg_rdata [NUM_PAGES];
    ifp_op_e           op;

    assign op = ifp_op_e'(acc_op);

    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        ifp_page #(.NUM_IDS(NUM_IDS), .IW(IW), .WW(WW)) u_page (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_hit   (set_valid && (set_page == PW'(p))),
            .set_id    (set_id),
            .acc_hit   (acc_valid && (acc_page == PW'(p))),
            .acc_we    (acc_we),
            .acc_op    (op),
            .acc_idx   (acc_idx),
            .acc_wdata (acc_wdata),
            .acc_wmask (acc_wmask),
            .rdata     (pg_rdata[p]),
            .irq       (irq[p])
        );
    end

    always_comb begin
        acc_rdata = '0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (acc_valid && (acc_page == PW'(p))) acc_rdata = pg_rdata[p];
        end
    end

endmodule

// File: tb/ifp_core_tb.sv
`timescale 1ns/1ps
module ifp_core_tb;

    localparam logic [2:0] S_DEL = 3'd0, S_THR = 3'd1, S_TOP = 3'd2,
                           S_PND = 3'd3, S_ENA = 3'd4;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_valid = 1'b0;
    logic [0:0]  set_page = '0;
    logic [5:0]  set_id = '0;
    logic        acc_valid = 1'b0;
    logic        acc_we = 1'b0;
    logic [2:0]  acc_op = '0;
    logic [0:0]  acc_page = '0;
    logic [0:0]  acc_idx = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_wmask = '0;
    logic [31:0] acc_rdata;
    logic [1:0]  irq;

    int    checks = 0;
    int    errors = 0;
    bit    mon_go = 1'b0;
    item_t sb[$];

    always #4 clk = ~clk;

    ifp_core #(.NUM_PAGES(2), .MAX_ID(63)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_page(set_page), .set_id(set_id),
        .acc_valid(acc_valid), .acc_we(acc_we), .acc_op(acc_op),
        .acc_page(acc_page), .acc_idx(acc_idx),
        .acc_wdata(acc_wdata), .acc_wmask(acc_wmask),
        .acc_rdata(acc_rdata), .irq(irq)
    );

    task automatic drive(bit av, bit we, logic [2:0] op, bit pg, bit idx,
                         logic [31:0] d, logic [31:0] m,
                         bit sv, bit sp, logic [5:0] sid,
                         bit chk, bit is_irq, logic [31:0] exp, string tag);
        item_t it;
        @(negedge clk);
        acc_valid = av; acc_we = we; acc_op = op; acc_page = pg; acc_idx = idx;
        acc_wdata = d; acc_wmask = m;
        set_valid = sv; set_page = sp; set_id = sid;
        if (chk) begin
            it.is_irq = is_irq; it.exp = exp; it.tag = tag;
            sb.push_back(it);
        end
        mon_go = chk;
    endtask

    task automatic wr(logic [2:0] op, bit pg, bit idx, logic [31:0] d, logic [31:0] m);
        drive(1, 1, op, pg, idx, d, m, 0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic rd(logic [2:0] op, bit pg, bit idx, logic [31:0] exp, string tag);
        drive(1, 0, op, pg, idx, 0, 0, 0, 0, 0, 1, 0, exp, tag);
    endtask

    task automatic setp(bit pg, logic [5:0] id);
        drive(0, 0, 0, 0, 0, 0, 0, 1, pg, id, 0, 0, 0, "");
    endtask

    task automatic claim_set(bit pg, bit sv, logic [5:0] id);
        drive(1, 1, S_TOP, pg, 0, 32'h0000_1234, 32'hFFFF_FFFF, sv, pg, id, 0, 0, 0, "");
    endtask

    task automatic ck_irq(logic [1:0] exp, string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, {30'd0, exp}, tag);
    endtask

    function automatic logic [31:0] topv(int id);
        return (32'(id) << 16) | 32'(id);
    endfunction

    // Monitor: pops the scoreboard on flagged cycles, well before the next edge.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (mon_go) begin
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard empty: actual=%h expected=item", acc_rdata);
                end else begin
                    item_t it;
                    logic [31:0] act;
                    it  = sb.pop_front();
                    act = it.is_irq ? {30'd0, irq} : acc_rdata;
                    checks++;
                    if (act !== it.exp) begin
                        errors++;
                        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(S_TOP, 0, 0, 0, "R1 top after reset");
        ck_irq(2'b00, "R1 irq after reset");
        rd(S_PND, 0, 0, 0, "R1 pending after reset");
        rd(S_THR, 0, 0, 0, "R1 threshold after reset");
        // R3 enables, bit 0 read-only
        wr(S_ENA, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(S_ENA, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(S_ENA, 0, 0, 32'hFFFF_FFFE, "R3 enable word0 bit0 stays 0");
        // R2 set-pending
        setp(0, 0);
        rd(S_PND, 0, 0, 0, "R2 identity 0 ignored");
        setp(0, 5);
        rd(S_PND, 0, 0, 32'h20, "R2 identity 5 pending");
        rd(S_TOP, 0, 0, topv(5), "R4 single winner");
        ck_irq(2'b00, "R6 no irq with delivery off");
        // R10 delivery
        wr(S_DEL, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(S_DEL, 0, 0, 32'h1, "R10 delivery bit only");
        ck_irq(2'b01, "R6 irq with delivery on");
        // R4 lowest wins
        setp(0, 40);
        setp(0, 3);
        rd(S_TOP, 0, 0, topv(3), "R4 lowest identity wins");
        // R5 threshold
        wr(S_THR, 0, 0, 32'd3, 32'hFFFF_FFFF);
        rd(S_TOP, 0, 0, 0, "R5 threshold equal to winner masks it");
        ck_irq(2'b00, "R6 irq low when all masked");
        wr(S_THR, 0, 0, 32'hFFFF_FFC4, 32'hFFFF_FFFF);
        rd(S_THR, 0, 0, 32'd4, "R5 threshold field width");
        rd(S_TOP, 0, 0, topv(3), "R5 threshold above winner");
        wr(S_THR, 0, 0, 32'd0, 32'hFFFF_FFFF);
        rd(S_TOP, 0, 0, topv(3), "R5 zero threshold masks nothing");
        // R7 claims
        claim_set(0, 0, 0);
        rd(S_PND, 0, 0, 32'h20, "R7 claim clears only winner");
        rd(S_TOP, 0, 0, topv(5), "R7 next winner after claim");
        claim_set(0, 0, 0);
        rd(S_TOP, 0, 0, topv(40), "R7 winner in word 1");
        rd(S_PND, 0, 1, 32'h100, "R3 identity 40 is word1 bit8");
        wr(S_ENA, 0, 1, 32'h0, 32'h100);
        rd(S_TOP, 0, 0, 0, "R7 no winner when disabled");
        ck_irq(2'b00, "R6 irq low without winner");
        claim_set(0, 0, 0);
        rd(S_PND, 0, 1, 32'h100, "R7 claim without winner no effect");
        wr(S_ENA, 0, 1, 32'h100, 32'h100);
        rd(S_TOP, 0, 0, topv(40), "R7 winner restored");
        // R8 claim with set-pending in same cycle
        claim_set(0, 1, 40);
        rd(S_PND, 0, 1, 32'h100, "R8 same identity stays pending");
        claim_set(0, 1, 7);
        rd(S_TOP, 0, 0, topv(7), "R8 other identity set");
        rd(S_PND, 0, 1, 32'h0, "R8 claimed identity cleared");
        // R3 masked pending write
        wr(S_PND, 0, 0, 32'h0000_0006, 32'h0000_00C2);
        rd(S_PND, 0, 0, 32'h2, "R3 masked pending write");
        rd(S_TOP, 0, 0, topv(1), "R4 identity 1 wins");
        // R9 second file
        setp(1, 9);
        rd(S_PND, 1, 0, 32'h200, "R9 page1 pending");
        rd(S_TOP, 1, 0, 0, "R9 page1 enables separate");
        ck_irq(2'b01, "R9 page1 irq stays low");
        wr(S_ENA, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd(S_TOP, 1, 0, topv(9), "R9 page1 winner");
        wr(S_DEL, 1, 0, 32'h1, 32'h1);
        ck_irq(2'b11, "R9 both irqs high");
        rd(S_TOP, 0, 0, topv(1), "R9 page0 unchanged");
        claim_set(1, 0, 0);
        ck_irq(2'b01, "R6 page1 irq drops after claim");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule